// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Mask

The block gathers interrupt requests from external pins and from on-chip peripherals. It gives each source a programmable 4-bit level. Every cycle it picks one winner among the pending, enabled requests. It offers that winner to the CPU only when the winner's level is strictly above the CPU's current 4-bit mask. An accepted request raises `req_o` and drives the active-low pin `irq_out_no` low. It also presents an 8-bit vector number and the level that the CPU loads into its mask.

External pins first pass through a two-flop synchronizer. Each external source is set to one of two modes: edge mode latches a rising edge until the CPU acknowledges that source, and level mode follows the synchronized pin. Peripheral requests are plain levels. A source whose level is 0 is disabled.

The CPU is modelled by a stub with two strobes. `ack_i` marks the start of exception processing for the request on offer. `mask_wr_i` marks the write of the new mask value, carried on `mask_i`. After an acknowledge, the block treats the acknowledged level as the mask until that write. For an edge-mode source the pin releases when the acknowledge arrives. For a level-mode source or a peripheral it releases when the mask is written. In both cases the pin stays low if a higher request is accepted meanwhile.

Top module: `irq_arbiter`

## Requirements
- R1: Among pending sources with a nonzero level, the winner is the source with the highest level.
- R2: Sources with equal levels are ordered by source index, and the lower index wins. External pins are indices 0..3 and peripherals are 4..7.
- R3: The winner is accepted only when its level is strictly greater than the effective mask. A level equal to or below the mask gives no request.
- R4: An acceptance shows one cycle later as `req_o`=1 and `irq_out_no`=0, together with `lvl_o` and `vec_o`. `vec_o` is 64+i for external pin i and 72+j for peripheral j.
- R5: A source programmed with level 0 never wins and is never accepted.
- R6: An edge-mode external request stays pending after the pin falls, until it is acknowledged. A level-mode request is pending only while the synchronized pin is high, and a drop before acceptance removes it.
- R7: When an edge-mode source is acknowledged and nothing higher is pending, `irq_out_no` returns high on the cycle after `ack_i`.
- R8: When a level-mode or peripheral source is acknowledged, `irq_out_no` stays low until the cycle after `mask_wr_i`.
- R9: From an acknowledge until the next `mask_wr_i`, the effective mask is the acknowledged level. Requests at or below that level are held off. A higher request is accepted, and it keeps `irq_out_no` low past the mask write.
- R10: The register port has three addresses. Address 0 holds the external levels and address 1 the peripheral levels, with source k of each group in bits 4k+3:4k. Bit k of address 2 set to 1 selects edge mode for pin k. Read data appears one cycle after the address.
- R11: After reset all levels and modes are 0, `req_o` is 0, `irq_out_no` is 1 and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 4 | External request pins, active high, asynchronous |
| per_req_i | input | 4 | Peripheral level requests |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| mask_i | input | 4 | CPU interrupt mask level |
| mask_wr_i | input | 1 | CPU writes a new mask value |
| ack_i | input | 1 | CPU starts exception processing for the offered request |
| req_o | output | 1 | Accepted request to CPU |
| vec_o | output | 8 | Vector number of the offered request |
| lvl_o | output | 4 | Level of the offered request, to be loaded into the mask |
| irq_out_no | output | 1 | Interrupt-out pin, active low |

## Verification
On every cycle, the assertions check four things. The picked source is pending with a nonzero level. An offered request always has the pin low. An edge latch is set only by a synchronized rising edge. A pending held release after a level acknowledge keeps the pin low. Only the bench scenarios can show the rest: the choice of winner across level and tie patterns, the strict mask comparison, and the different release points for edge and level sources. The same holds for nested acceptance during a held release, the loss of a level request dropped before acceptance, and register readback.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W          = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int REG_W          = LVL_W * FIELDS_PER_REG;
  localparam int VEC_W          = 8;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_ext_front.sv
module irq_ext_front #(
  parameter int N_EXT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] pin_i,
  input  logic [N_EXT-1:0] edge_mode_i,
  input  logic [N_EXT-1:0] clr_i,
  output logic [N_EXT-1:0] pend_o
);
  logic [N_EXT-1:0] s1_q, s2_q, s3_q, latch_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0; latch_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      latch_q <= edge_mode_i & (rise | (latch_q & ~clr_i));
    end
  end

  assign rise = s2_q & ~s3_q;

  for (genvar i = 0; i < N_EXT; i++) begin : g_pend
    assign pend_o[i] = edge_mode_i[i] ? latch_q[i] : s2_q[i];

    // R6
    latch_from_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(latch_q[i]) |-> $past(rise[i]));
  end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int N_EXT = 4,
  parameter int AW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output lvl_t             lvl_o [N_SRC],
  output logic [N_EXT-1:0] edge_mode_o
);
  localparam int N_PREG = (N_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

  logic [REG_W-1:0] prio_q [N_PREG];
  logic [N_EXT-1:0] mode_q;
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N_PREG; r++) prio_q[r] <= '0;
      mode_q  <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) begin
        for (int r = 0; r < N_PREG; r++)
          if (int'(addr_i) == r) prio_q[r] <= wdata_i;
        if (int'(addr_i) == N_PREG) mode_q <= wdata_i[N_EXT-1:0];
      end
      rdata_o <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < N_PREG; r++)
      if (int'(addr_i) == r) rd_mux = prio_q[r];
    if (int'(addr_i) == N_PREG) rd_mux[N_EXT-1:0] = mode_q;
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_lvl
    assign lvl_o[s] = prio_q[s / FIELDS_PER_REG][(s % FIELDS_PER_REG) * LVL_W +: LVL_W];
  end

  assign edge_mode_o = mode_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  lvl_t          lvl_i [N],
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output lvl_t          lvl_o
);
  // scan from the lowest-priority index so lower indices win ties
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i] && lvl_i[i] != '0 && lvl_i[i] >= lvl_o) begin
        any_o = 1'b1;
        idx_o = IW'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int   N_EXT    = 4,
  parameter int   N_PER    = 4,
  parameter vec_t EXT_VEC0 = 8'd64,
  parameter vec_t PER_VEC0 = 8'd72,
  localparam int  N_SRC    = N_EXT + N_PER,
  localparam int  N_PREG   = (N_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG,
  localparam int  AW       = $clog2(N_PREG + 1),
  localparam int  IW       = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] irq_pin_i,
  input  logic [N_PER-1:0] per_req_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             mask_wr_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             irq_out_no
);
  lvl_t             src_lvl [N_SRC];
  logic [N_EXT-1:0] edge_mode, ext_pend, ext_clr;
  logic [N_SRC-1:0] all_pend;
  logic             pick_any, accept, ack_fire, src_edge;
  logic [IW-1:0]    pick_idx, src_q;
  lvl_t             pick_lvl, eff_mask, lvl_q, wait_lvl_q, wait_lvl_d;
  logic             req_q, pin_low_q, wait_q, wait_d, hold_q, hold_d;
  vec_t             vec_q, vec_d;

  irq_prio_regs #(.N_SRC(N_SRC), .N_EXT(N_EXT), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .lvl_o(src_lvl), .edge_mode_o(edge_mode)
  );

  irq_ext_front #(.N_EXT(N_EXT)) u_front (
    .clk_i, .rst_ni,
    .pin_i(irq_pin_i), .edge_mode_i(edge_mode), .clr_i(ext_clr), .pend_o(ext_pend)
  );

  assign all_pend = {per_req_i, ext_pend};

  irq_pick #(.N(N_SRC), .IW(IW)) u_pick (
    .pend_i(all_pend), .lvl_i(src_lvl),
    .any_o(pick_any), .idx_o(pick_idx), .lvl_o(pick_lvl)
  );

  assign ack_fire = ack_i & req_q;

  for (genvar i = 0; i < N_EXT; i++) begin : g_clr
    assign ext_clr[i] = ack_fire && (int'(src_q) == i);
  end

  always_comb begin
    src_edge = 1'b0;
    for (int i = 0; i < N_EXT; i++)
      if (int'(src_q) == i) src_edge = edge_mode[i];
  end

  // acknowledged level stands in for the mask until the CPU writes it
  always_comb begin
    if (ack_fire)    eff_mask = lvl_q;
    else if (wait_q) eff_mask = wait_lvl_q;
    else             eff_mask = mask_i;
  end

  assign accept     = pick_any && (pick_lvl > eff_mask);
  assign wait_d     = ack_fire | (wait_q & ~mask_wr_i);
  assign wait_lvl_d = ack_fire ? lvl_q : wait_lvl_q;
  assign hold_d     = ack_fire ? ~src_edge : hold_q;

  always_comb begin
    if (int'(pick_idx) < N_EXT) vec_d = EXT_VEC0 + vec_t'(pick_idx);
    else                        vec_d = PER_VEC0 + vec_t'(int'(pick_idx) - N_EXT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      pin_low_q  <= 1'b0;
      src_q      <= '0;
      lvl_q      <= '0;
      vec_q      <= '0;
      wait_q     <= 1'b0;
      wait_lvl_q <= '0;
      hold_q     <= 1'b0;
    end else begin
      req_q      <= accept;
      pin_low_q  <= accept | (wait_d & hold_d);
      src_q      <= pick_idx;
      lvl_q      <= accept ? pick_lvl : '0;
      vec_q      <= vec_d;
      wait_q     <= wait_d;
      wait_lvl_q <= wait_lvl_d;
      hold_q     <= hold_d;
    end
  end

  assign req_o      = req_q;
  assign vec_o      = vec_q;
  assign lvl_o      = lvl_q;
  assign irq_out_no = ~pin_low_q;

  // R1
  chosen_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_any |-> all_pend[pick_idx]);

  // R5
  nonzero_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> lvl_o != '0);

  // R4
  req_pin_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !irq_out_no);

  // R8
  held_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && hold_q) |-> !irq_out_no);
endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  irq_pin = '0, per_req = '0, mask = '0;
  logic        reg_we = 1'b0, mask_wr = 1'b0, ack = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        req, irq_out_n;
  logic [7:0]  vec;
  logic [3:0]  lvl;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_arbiter dut (
    .clk_i(clk), .rst_ni, .irq_pin_i(irq_pin), .per_req_i(per_req),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mask_i(mask), .mask_wr_i(mask_wr), .ack_i(ack),
    .req_o(req), .vec_o(vec), .lvl_o(lvl), .irq_out_no(irq_out_n)
  );

  typedef struct packed {
    logic [3:0] per;
    logic [3:0] msk;
    logic       e_req;
    logic [7:0] e_vec;
    logic [3:0] e_lvl;
  } vec_ent_t;

  // levels: p0=5 p1=9 p2=9 p3=0
  localparam int NV = 9;
  localparam vec_ent_t TBL [NV] = '{
    '{4'b0001, 4'd0, 1'b1, 8'd72, 4'd5},  // R1 R4
    '{4'b0001, 4'd5, 1'b0, 8'd0,  4'd0},  // R3 equal
    '{4'b0001, 4'd4, 1'b1, 8'd72, 4'd5},  // R3 above
    '{4'b0110, 4'd0, 1'b1, 8'd73, 4'd9},  // R2 tie
    '{4'b0100, 4'd8, 1'b1, 8'd74, 4'd9},  // R3
    '{4'b1000, 4'd0, 1'b0, 8'd0,  4'd0},  // R5 disabled
    '{4'b0111, 4'd9, 1'b0, 8'd0,  4'd0},  // R3 below
    '{4'b0011, 4'd6, 1'b1, 8'd73, 4'd9},  // R1
    '{4'b0000, 4'd0, 1'b0, 8'd0,  4'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk); reg_addr = a;
    @(negedge clk); chk(tag, reg_rdata, e);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic set_mask(input logic [3:0] m);
    @(negedge clk); mask = m; mask_wr = 1'b1;
    @(negedge clk); mask_wr = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R11 act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
    chk("R11 req", req, 0);
    chk("R11 pin", irq_out_n, 1);
    chk("R11 rdata", reg_rdata, 0);

    wr(2'd0, 16'hC377);   // ext0=7 ext1=7 ext2=3 ext3=12
    wr(2'd1, 16'h0995);
    wr(2'd2, 16'h0005);   // ext0, ext2 edge
    rd(2'd0, 16'hC377, "R10 reg0");
    rd(2'd1, 16'h0995, "R10 reg1");
    rd(2'd2, 16'h0005, "R10 mode");

    for (int k = 0; k < NV; k++) begin
      @(negedge clk); per_req = TBL[k].per; mask = TBL[k].msk;
      @(negedge clk);
      chk($sformatf("R1/R3 tbl%0d req", k), req, TBL[k].e_req);
      chk($sformatf("R4 tbl%0d pin", k), irq_out_n, !TBL[k].e_req);
      if (TBL[k].e_req) begin
        chk($sformatf("R2/R4 tbl%0d vec", k), vec, TBL[k].e_vec);
        chk($sformatf("R4 tbl%0d lvl", k), lvl, TBL[k].e_lvl);
      end
    end

    // external level source outranks peripheral
    @(negedge clk); per_req = 4'b0010; irq_pin = 4'b1000;
    cyc(6);
    chk("R1 ext3 vec", vec, 8'd67);
    @(negedge clk); per_req = '0; irq_pin = '0;
    cyc(6);

    // R6 level source dropped before acceptance vanishes
    @(negedge clk); irq_pin = 4'b0010;
    cyc(6);
    chk("R6 lvl req", req, 1);
    chk("R6 lvl vec", vec, 8'd65);
    @(negedge clk); irq_pin = '0;
    cyc(6);
    chk("R6 lvl dropped", req, 0);

    // R6 edge latch, R7 release on ack
    @(negedge clk); irq_pin = 4'b0001;
    cyc(2);
    irq_pin = '0;
    cyc(10);
    chk("R6 edge held", req, 1);
    chk("R6 edge vec", vec, 8'd64);
    do_ack();
    chk("R7 edge pin", irq_out_n, 1);
    chk("R7 edge req", req, 0);
    set_mask(4'd7);
    set_mask(4'd0);
    cyc(3);
    chk("R6 edge cleared", req, 0);

    // R8 level release waits for mask write
    @(negedge clk); per_req = 4'b0001;
    @(negedge clk);
    chk("R8 req", req, 1);
    do_ack();
    chk("R9 same lvl held off", req, 0);
    chk("R8 pin held", irq_out_n, 0);
    cyc(3);
    chk("R8 pin still", irq_out_n, 0);
    set_mask(4'd5);
    chk("R8 pin release", irq_out_n, 1);
    @(negedge clk); per_req = '0;
    set_mask(4'd0);

    // R9 nested higher request keeps pin low
    @(negedge clk); per_req = 4'b0001;
    @(negedge clk);
    do_ack();
    @(negedge clk); per_req = 4'b0011;
    @(negedge clk);
    chk("R9 nested req", req, 1);
    chk("R9 nested vec", vec, 8'd73);
    set_mask(4'd5);
    chk("R9 pin stays low", irq_out_n, 0);
    chk("R9 nested still", req, 1);

    summary();
    $finish;
  end
endmodule